// File: doc/BRIEF.md
# Low-Transition Scan Pattern Source

This block feeds the serial input of a scan chain with pseudo-random test data that changes value far less often than the raw output of a linear feedback shift register. A maximal-length Fibonacci LFSR steps once on every shift clock. A K-input AND gate watches the low K stages of the register. Its result drives a toggle flip-flop, and that flip-flop is the bit sent into the chain. The chain therefore receives long runs of one value. A run ends only when all K watched stages are 1 at the same time, which happens about once in 2^K shifts. Neighbouring scan cells become strongly correlated, and the switching activity during scan load falls.

Software or a test controller can load a seed at any time. Loading a seed also clears the toggle flip-flop and restarts the bit count, so a fresh vector starts from a known point. An all-zero seed would lock the register, so the block rejects it and loads a built-in default instead. A counter of the chain length raises a one-cycle flag after each full scan vector has been shifted out.

Top module: `lt_scan_src`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block goes to a fixed state: `scan_bit` is 0, `vector_done` is 0, the bit count is 0, and the LFSR holds the default seed (16'hACE1 at default parameters).
- R2: A clock edge with `seed_load` high and a non-zero `seed_value` loads that value into the LFSR. The same edge clears `scan_bit` to 0 and restarts the bit count at zero.
- R3: A clock edge with `seed_load` high and `seed_value` equal to zero loads the default seed 16'hACE1 in place of zero. Otherwise it behaves as in R2.
- R4: A shift edge (`shift_en` high, `seed_load` low) moves the LFSR one place toward its MSB. The new bit 0 is the XOR of stages 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1, tap mask 16'hB400).
- R5: On a shift edge, `scan_bit` inverts if LFSR stages [AND_K-1:0] (stages 2..0 at default) are all 1 just before the edge. If they are not all 1, `scan_bit` keeps its value.
- R6: A clock edge with both `seed_load` and `shift_en` low leaves the LFSR, `scan_bit` and the bit count unchanged, and drives `vector_done` to 0.
- R7: `vector_done` is high for exactly the one cycle that follows every CHAIN_LEN-th shift edge (24 at default), counted from reset or from the last seed load. At all other times it is 0.
- R8: When `seed_load` and `shift_en` are both high, the load takes effect and no shift happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Load `seed_value` into the LFSR, clear the scan bit and restart the bit count |
| seed_value | input | LFSR_W | Seed to load; zero selects the default seed |
| shift_en | input | 1 | Advance the LFSR and the scan bit by one shift |
| scan_bit | output | 1 | Serial bit for the scan chain input (toggle flip-flop output) |
| vector_done | output | 1 | One-cycle pulse after each complete scan vector |

## Verification
A corrupted LFSR state cannot be seen on the pins at once. It shows only when it changes the time at which the AND gate fires. At K=3 that is usually within a handful of shifts, so the bench compares `scan_bit` against an independent model on every cycle, over long shift runs. A wrong bit count, or a count that is not restarted by a load, shows as a `vector_done` pulse on the wrong cycle within one chain length. A wrong reset or load of the toggle flip-flop shows as a wrong `scan_bit` on the first cycle after the event.

// File: rtl/lts_pkg.sv
// Package: types and defaults shared by the low-transition scan source.
// Assumes a 16-bit default register; other widths must supply their own taps and seed.
package lts_pkg;

    // Per-cycle operation decoded once at the top and shared by every stage.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } lts_op_e;

    localparam int unsigned  DEF_LFSR_W = 16;
    // x^16 + x^14 + x^13 + x^11 + 1, expressed as the set of stages XORed into bit 0
    localparam logic [15:0]  DEF_TAPS   = 16'hB400;
    localparam logic [15:0]  DEF_SEED   = 16'hACE1;
    localparam int unsigned  DEF_AND_K  = 3;
    localparam int unsigned  DEF_CHAIN  = 24;

endpackage

// File: rtl/lts_lfsr.sv
// Module: Fibonacci LFSR that shifts toward the MSB and feeds the XOR of its tapped stages
// into bit 0. Assumes TAPS describes a maximal-length polynomial and SEED is non-zero.
module lts_lfsr
    import lts_pkg::*;
#(
    parameter int unsigned     W    = DEF_LFSR_W,
    parameter logic [W-1:0]    TAPS = DEF_TAPS,
    parameter logic [W-1:0]    SEED = DEF_SEED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lts_op_e       op,
    input  logic [W-1:0]  seed_value,
    output logic [W-1:0]  state_q
);

    logic          fb_bit;
    logic [W-1:0]  load_val;

    // Feedback: parity of the tapped stages.
    always_comb fb_bit = ^(state_q & TAPS);

    // Seed filter: replace a locking all-zero seed by the default.
    always_comb load_val = (seed_value == '0) ? SEED : seed_value;

    // State register: reset, load, shift or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            case (op)
                OP_LOAD:  state_q <= load_val;
                OP_SHIFT: state_q <= {state_q[W-2:0], fb_bit};
                default:  state_q <= state_q;
            endcase
        end
    end

    // R3
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R3
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD && seed_value == '0) |=> state_q == SEED);

    // R4
    shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> state_q[W-1:1] == $past(state_q[W-2:0]));

    // R6
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(state_q));

endmodule

// File: rtl/lts_toggle.sv
// Module: K-input AND over the low LFSR stages driving a toggle flip-flop whose output
// is the scan-in bit. Assumes 1 <= K <= W; the AND samples the state before the shift.
module lts_toggle
    import lts_pkg::*;
#(
    parameter int unsigned W = DEF_LFSR_W,
    parameter int unsigned K = DEF_AND_K
) (
    input  logic          clk,
    input  logic          rst_n,
    input  lts_op_e       op,
    input  logic [W-1:0]  lfsr_state,
    output logic          bit_q
);

    logic [K-1:0] watch;
    logic         and_hit;

    // Stage selection: one watched stage per AND input.
    for (genvar gi = 0; gi < K; gi++) begin : g_watch
        assign watch[gi] = lfsr_state[gi];
    end

    // AND gate: fires only when every watched stage is 1.
    always_comb and_hit = &watch;

    // Toggle flip-flop: inverts on a firing shift, cleared by reset and load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (op == OP_LOAD) begin
            bit_q <= 1'b0;
        end else if (op == OP_SHIFT && and_hit) begin
            bit_q <= ~bit_q;
        end
    end

    // R5
    toggle_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT && and_hit) |=> bit_q != $past(bit_q));

    // R5
    toggle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT && !and_hit) |=> $stable(bit_q));

    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(bit_q));

    // R2
    toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> !bit_q);

endmodule

// File: rtl/lts_vec_count.sv
// Module: counts shifted bits and pulses a registered flag after every M of them.
// Assumes M >= 2; a load restarts the count so the next vector is complete.
module lts_vec_count
    import lts_pkg::*;
#(
    parameter int unsigned M = DEF_CHAIN
) (
    input  logic     clk,
    input  logic     rst_n,
    input  lts_op_e  op,
    output logic     done_q
);

    localparam int unsigned CNT_W = (M > 1) ? $clog2(M) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(M - 1);

    logic [CNT_W-1:0] count_q;
    logic             at_last;

    // Wrap detect on the bit that completes a vector.
    always_comb at_last = (count_q == LAST);

    // Bit counter and vector flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            case (op)
                OP_LOAD: begin
                    count_q <= '0;
                    done_q  <= 1'b0;
                end
                OP_SHIFT: begin
                    count_q <= at_last ? '0 : count_q + 1'b1;
                    done_q  <= at_last;
                end
                default: begin
                    count_q <= count_q;
                    done_q  <= 1'b0;
                end
            endcase
        end
    end

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> count_q == '0);

endmodule

// File: rtl/lt_scan_src.sv
// Module: top of the low-transition scan pattern source. Decodes the controls into one
// operation per cycle (load over shift over hold) and wires LFSR, toggle stage and counter.
// Assumes synchronous active-low reset and one scan shift per enabled clock.
module lt_scan_src
    import lts_pkg::*;
#(
    parameter int unsigned          LFSR_W    = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0]    TAPS      = DEF_TAPS,
    parameter logic [LFSR_W-1:0]    SEED      = DEF_SEED,
    parameter int unsigned          AND_K     = DEF_AND_K,
    parameter int unsigned          CHAIN_LEN = DEF_CHAIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seed_load,
    input  logic [LFSR_W-1:0]  seed_value,
    input  logic               shift_en,
    output logic               scan_bit,
    output logic               vector_done
);

    lts_op_e            op;
    logic [LFSR_W-1:0]  lfsr_state;

    // Operation decode: a seed load wins over a shift.
    always_comb begin
        if (seed_load)      op = OP_LOAD;
        else if (shift_en)  op = OP_SHIFT;
        else                op = OP_HOLD;
    end

    lts_lfsr #(.W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .seed_value (seed_value),
        .state_q    (lfsr_state)
    );

    lts_toggle #(.W(LFSR_W), .K(AND_K)) u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .lfsr_state (lfsr_state),
        .bit_q      (scan_bit)
    );

    lts_vec_count #(.M(CHAIN_LEN)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .done_q (vector_done)
    );

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && shift_en) |=> (!vector_done && !scan_bit));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!scan_bit && !vector_done));

endmodule

// File: tb/lt_scan_src_bench.sv
// Bench: scoreboard. The driver task applies one cycle of stimulus, steps an independent
// model and queues the expected outputs; the monitor pops one entry after each rising edge.
module lt_scan_src_bench;

    localparam int unsigned W     = 16;
    localparam logic [15:0] TAPS  = 16'hB400;
    localparam logic [15:0] DSEED = 16'hACE1;
    localparam int unsigned K     = 3;
    localparam int unsigned M     = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_value = '0;
    logic        shift_en = 1'b0;
    logic        scan_bit;
    logic        vector_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic  q_scan[$];
    logic  q_done[$];
    string q_tag[$];

    // model state
    logic [15:0] m_lfsr = DSEED;
    logic        m_tff  = 1'b0;
    int          m_cnt  = 0;
    logic        m_done = 1'b0;

    always #10 clk = ~clk;

    lt_scan_src u_lt_scan_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_load   (seed_load),
        .seed_value  (seed_value),
        .shift_en    (shift_en),
        .scan_bit    (scan_bit),
        .vector_done (vector_done)
    );

    task automatic step(input logic r, input logic l, input logic e, input logic [15:0] s);
        string tag;
        logic  fb;
        @(negedge clk);
        rst_n = r; seed_load = l; shift_en = e; seed_value = s;
        if (!r) begin
            m_lfsr = DSEED; m_tff = 1'b0; m_cnt = 0; m_done = 1'b0;
            tag = "R1";
        end else if (l) begin
            m_lfsr = (s == 16'h0) ? DSEED : s;
            m_tff = 1'b0; m_cnt = 0; m_done = 1'b0;
            tag = e ? "R8" : ((s == 16'h0) ? "R3" : "R2");
        end else if (e) begin
            if (m_lfsr[2] & m_lfsr[1] & m_lfsr[0]) m_tff = ~m_tff;
            fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10];
            m_lfsr = {m_lfsr[14:0], fb};
            m_cnt = m_cnt + 1;
            m_done = (m_cnt == M);
            if (m_cnt == M) m_cnt = 0;
            tag = m_done ? "R7" : "R4 R5";
        end else begin
            m_done = 1'b0;
            tag = "R6";
        end
        q_scan.push_back(m_tff);
        q_done.push_back(m_done);
        q_tag.push_back(tag);
    endtask

    task automatic shifts(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1, 16'h0);
    endtask

    // Monitor: compare outputs two time units after every rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_scan.size() > 0) begin
                logic  es, ed;
                string t;
                es = q_scan.pop_front();
                ed = q_done.pop_front();
                t  = q_tag.pop_front();
                tests++;
                if (scan_bit !== es || vector_done !== ed) begin
                    fails++;
                    $display("FAIL %s: scan_bit=%b vector_done=%b expected scan_bit=%b vector_done=%b at %0t",
                             t, scan_bit, vector_done, es, ed, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        // R1 reset state
        repeat (3) step(1'b0, 1'b0, 1'b0, 16'h0);
        // R4 R5 R7 long run from default seed, two vectors and more
        shifts(60);
        // R6 idle hold
        repeat (5) step(1'b1, 1'b0, 1'b0, 16'h0);
        // gapped shifting
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, (i % 3) != 0, 16'h0);
        // R2 explicit seed
        step(1'b1, 1'b1, 1'b0, 16'h1234);
        shifts(50);
        // R3 zero seed maps to default
        step(1'b1, 1'b1, 1'b0, 16'h0000);
        shifts(30);
        // R8 load and shift together
        step(1'b1, 1'b1, 1'b1, 16'hFFFF);
        shifts(30);
        // R7 reload mid-vector restarts the count
        shifts(10);
        step(1'b1, 1'b1, 1'b0, 16'h8001);
        shifts(26);
        // R1 reset mid-run, then resume
        repeat (2) step(1'b0, 1'b0, 1'b1, 16'h0);
        shifts(30);
        step(1'b1, 1'b0, 1'b0, 16'h0);
        repeat (3) @(posedge clk);
        #5;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule